// File: doc/BRIEF.md
# ADC Result Sequencing and Buffering Controller

This block is the digital half of a successive-conversion analog-to-digital converter. A converter model tells it when a conversion starts and when one finishes, together with the finished result word. The block decides where each result is kept and which input channel is converted next. It also decides when software or a DMA engine is told that results are ready.

A single group size, N, ties three events together: the interrupt, the return of the result write pointer to slot 0, and the restart of the channel scan. In sequential mode, results fill a 16-slot buffer in strict conversion order. In DMA mode, every result lands in slot 0. A request strobe follows each result and an address-increment strobe follows each completed group. An overrun flag records a slot-0 result that was replaced before anyone read it. A sticky DONE flag reports the most recent conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `cfg_group_m1` holds N-1, so N runs from 1 to 32. `irq` goes high in the cycle after the N-th accepted conversion counted since enable or since the previous group end. It stays high until `irq_clr`; a group end in the same cycle as `irq_clr` keeps it high.
- R2: With `cfg_dma_en`=0, the k-th result of a group (k counted from 0) is written to slot k mod 16. The slot depends only on conversion order, never on the channel. After every group end the next result goes to slot 0.
- R3: With `cfg_dma_en`=1, every result is written to slot 0 and the other slots keep their contents. `dma_req` is a one-cycle pulse in the cycle after each accepted conversion, and it stays low in sequential mode.
- R4: `dma_addr_inc` is a one-cycle pulse in the cycle after a group-ending conversion, and only while `cfg_dma_en`=1.
- R5: In DMA mode, a result that arrives while the previous slot-0 result is still unread sets `overrun`. A cycle with `rd_en`=1 and `rd_addr`=0 marks slot 0 as read and clears `overrun`. `overrun` never rises in sequential mode.
- R6: `done` is cleared by an accepted `conv_start` or by `done_clr`. It is set by an accepted `conv_done`, which wins over both, and it otherwise holds its value through the following sample phase.
- R7: Bit i of `cfg_scan_mask` selects channel i. With scan enabled, `cur_chan` is the lowest selected channel at or above the scan index. After each conversion the index moves just past the channel that was converted, wrapping to the lowest selected channel. At a group end the index returns to 0. With scan disabled, `cur_chan` is 0.
- R8: While `enable`=0, the group counter, write pointer and scan index are held at 0, and `irq` is cleared. `conv_done` and `conv_start` are ignored, so the buffer and `done` keep their values.
- R9: After reset, `irq`, `done`, `overrun`, `dma_req` and `dma_addr_inc` are 0 and every buffer slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block on; low holds the sequencing state at zero |
| cfg_group_m1 | input | 5 | Conversions per group minus one |
| cfg_scan_en | input | 1 | Channel scanning on |
| cfg_scan_mask | input | 16 | Channel selection, bit i selects channel i |
| cfg_dma_en | input | 1 | Single-slot DMA mode |
| conv_start | input | 1 | Converter begins a conversion |
| conv_done | input | 1 | Converter finished; result valid on conv_data |
| conv_data | input | 12 | Result word |
| done_clr | input | 1 | Software clear of DONE |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| rd_en | input | 1 | Read strobe; slot 0 read marks it consumed |
| rd_addr | input | 4 | Slot to read |
| rd_data | output | 12 | Contents of the addressed slot |
| cur_chan | output | 4 | Channel to convert next |
| done | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | Interrupt flag |
| overrun | output | 1 | Unread slot-0 result replaced in DMA mode |
| dma_req | output | 1 | Transfer request pulse |
| dma_addr_inc | output | 1 | Destination address step pulse |

## Verification
The assertions assume that the configuration inputs (group size, scan mask, scan enable and DMA mode) change only while `enable` is low. A group size that shrinks below the current count mid-group would postpone the group end until the counter wraps. They also assume that `conv_start` and `conv_done` never arrive in the same cycle, since a real converter cannot begin and finish at once. The stimulus follows both rules: every configuration change is wrapped in a one-cycle disable, and each conversion is a start pulse followed one cycle later by a completion pulse.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the ADC result sequencer.
// Assumes: nothing; holds default sizes and the storage mode type.
package adc_seq_pkg;
    localparam int DEF_DATA_W = 12;
    localparam int DEF_NUM_BUF = 16;
    localparam int DEF_NUM_CH = 16;
    localparam int DEF_CNT_W = 5;

    typedef enum logic {
        STORE_SEQ    = 1'b0,
        STORE_SINGLE = 1'b1
    } store_mode_e;
endpackage

// File: rtl/adc_seq_counter.sv
// Group counter and sequential write pointer.
// Counts accepted conversions and flags the one that ends a group of
// group_m1+1, then returns both counter and pointer to zero.
// Assumes: group_m1 only changes while enable is low.
module adc_seq_counter #(
    parameter int CNT_W = 5,
    parameter int NUM_BUF = 16,
    localparam int PTR_W = $clog2(NUM_BUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             conv_ev,
    input  logic [CNT_W-1:0] group_m1,
    output logic [PTR_W-1:0] wptr,
    output logic             group_end
);
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] ptr_q;

    // Flag the conversion that completes the current group.
    assign group_end = conv_ev && (cnt_q == group_m1);
    assign wptr = ptr_q;

    // Advance count and pointer per conversion, clear at group end or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            ptr_q <= '0;
        end else if (conv_ev) begin
            if (group_end) begin
                cnt_q <= '0;
                ptr_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                ptr_q <= (ptr_q == PTR_W'(NUM_BUF - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    assert_ptr_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        group_end |=> (wptr == '0));
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && conv_ev && !group_end) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_disable_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0 && wptr == '0));
endmodule

// File: rtl/adc_scan_stepper.sv
// Channel scan stepper.
// Picks the lowest selected channel at or above the scan index, wrapping
// to the lowest selected one; moves the index past each converted channel
// and back to zero at a group end.
// Assumes: NUM_CH is a power of two; mask only changes while disabled.
module adc_scan_stepper #(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scan_en,
    input  logic [NUM_CH-1:0] mask,
    input  logic              adv,
    input  logic              restart,
    output logic [CH_W-1:0]   chan
);
    logic [CH_W-1:0] idx_q;
    logic [CH_W-1:0] pick;

    // Search the mask: lowest set bit overall, overridden by lowest at/above index.
    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) pick = CH_W'(i);
        end
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && (CH_W'(i) >= idx_q)) pick = CH_W'(i);
        end
    end

    assign chan = scan_en ? pick : '0;

    // Move the scan index after each conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !scan_en) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= restart ? '0 : pick + 1'b1;
        end
    end

    assert_chan_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && (|mask)) |-> mask[chan]);
    assert_restart_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && scan_en && adv && restart) |=> (idx_q == '0));
endmodule

// File: rtl/adc_result_store.sv
// Result buffer with single-slot overrun tracking.
// Sequential mode writes the slot given by the pointer; single mode always
// writes slot 0 and tracks whether that slot was read before replacement.
// Assumes: rd_addr stays below NUM_BUF.
module adc_result_store
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NUM_BUF = 16,
    localparam int PTR_W = $clog2(NUM_BUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ev,
    input  store_mode_e       mode,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              overrun
);
    logic [DATA_W-1:0] mem_q [NUM_BUF];
    logic [PTR_W-1:0]  waddr;
    logic              unread_q;
    logic              ovr_q;
    logic              rd_slot0;
    logic              unread_left;
    logic              single_wr;

    // Select the target slot from the storage mode.
    assign waddr = (mode == STORE_SINGLE) ? '0 : wptr;
    assign single_wr = wr_ev && (mode == STORE_SINGLE);
    assign rd_slot0 = rd_en && (rd_addr == '0);
    assign unread_left = unread_q && !rd_slot0;
    assign rd_data = mem_q[rd_addr];
    assign overrun = ovr_q;

    // Store each accepted result in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BUF; i++) mem_q[i] <= '0;
        end else if (wr_ev) begin
            mem_q[waddr] <= wr_data;
        end
    end

    // Track an unread slot-0 result and its replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unread_q <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            unread_q <= unread_left;
            ovr_q    <= ovr_q && !rd_slot0;
            if (single_wr) begin
                unread_q <= 1'b1;
                if (unread_left) ovr_q <= 1'b1;
            end
        end
    end

    assert_ovr_single_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> ($past(mode) == STORE_SINGLE));
    assert_read_clears_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_slot0 && !single_wr) |=> !ovr_q);
    assert_single_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        single_wr |=> (mem_q[0] == $past(wr_data)));
endmodule

// File: rtl/adc_status_flags.sv
// DONE, interrupt and DMA strobe generation.
// DONE is sticky between a completion and the next start or software clear;
// the interrupt latches at each group end; DMA strobes are one-cycle pulses.
// Assumes: start and completion events never coincide.
module adc_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic conv_ev,
    input  logic start_ev,
    input  logic group_end,
    input  logic dma_mode,
    input  logic done_clr,
    input  logic irq_clr,
    output logic done,
    output logic irq,
    output logic dma_req,
    output logic dma_inc
);
    // Sticky DONE: completion sets, start or software clear resets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (conv_ev) begin
            done <= 1'b1;
        end else if (start_ev || done_clr) begin
            done <= 1'b0;
        end
    end

    // Interrupt flag: set at group end, cleared by software or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            irq <= 1'b0;
        end else if (group_end) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    // One-cycle DMA strobes after each conversion and each group end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req <= 1'b0;
            dma_inc <= 1'b0;
        end else begin
            dma_req <= conv_ev && dma_mode;
            dma_inc <= group_end && dma_mode;
        end
    end

    assert_irq_on_group_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        group_end |=> irq);
    assert_done_on_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ev |=> done);
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_ev && !done_clr) |=> done);
    assert_inc_dma_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_inc |-> ($past(dma_mode) && $past(group_end)));
    assert_disable_clears_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC result sequencing and buffering controller.
// Accepts converter events while enabled and routes them to the group
// counter, scan stepper, result store and status flags.
// Assumes: configuration is changed only while enable is low.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int NUM_BUF = DEF_NUM_BUF,
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CNT_W = DEF_CNT_W,
    localparam int PTR_W = $clog2(NUM_BUF),
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  cfg_group_m1,
    input  logic              cfg_scan_en,
    input  logic [NUM_CH-1:0] cfg_scan_mask,
    input  logic              cfg_dma_en,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              done_clr,
    input  logic              irq_clr,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CH_W-1:0]   cur_chan,
    output logic              done,
    output logic              irq,
    output logic              overrun,
    output logic              dma_req,
    output logic              dma_addr_inc
);
    logic             conv_ev;
    logic             start_ev;
    logic             group_end;
    logic [PTR_W-1:0] wptr;
    store_mode_e      mode;

    // Gate converter events with the block enable.
    assign conv_ev  = conv_done && enable;
    assign start_ev = conv_start && enable;
    assign mode     = cfg_dma_en ? STORE_SINGLE : STORE_SEQ;

    adc_seq_counter #(.CNT_W(CNT_W), .NUM_BUF(NUM_BUF)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .conv_ev   (conv_ev),
        .group_m1  (cfg_group_m1),
        .wptr      (wptr),
        .group_end (group_end)
    );

    adc_scan_stepper #(.NUM_CH(NUM_CH)) i_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .scan_en (cfg_scan_en),
        .mask    (cfg_scan_mask),
        .adv     (conv_ev),
        .restart (group_end),
        .chan    (cur_chan)
    );

    adc_result_store #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ev   (conv_ev),
        .mode    (mode),
        .wptr    (wptr),
        .wr_data (conv_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .overrun (overrun)
    );

    adc_status_flags i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .conv_ev   (conv_ev),
        .start_ev  (start_ev),
        .group_end (group_end),
        .dma_mode  (cfg_dma_en),
        .done_clr  (done_clr),
        .irq_clr   (irq_clr),
        .done      (done),
        .irq       (irq),
        .dma_req   (dma_req),
        .dma_inc   (dma_addr_inc)
    );

    assert_no_req_seq_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(cfg_dma_en));
endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [4:0]  cfg_group_m1 = '0;
    logic        cfg_scan_en = 1'b0;
    logic [15:0] cfg_scan_mask = '0;
    logic        cfg_dma_en = 1'b0;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        done_clr = 1'b0;
    logic        irq_clr = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic [3:0]  cur_chan;
    logic        done, irq, overrun, dma_req, dma_addr_inc;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_group_m1(cfg_group_m1),
        .cfg_scan_en(cfg_scan_en), .cfg_scan_mask(cfg_scan_mask), .cfg_dma_en(cfg_dma_en),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .done_clr(done_clr), .irq_clr(irq_clr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .cur_chan(cur_chan), .done(done), .irq(irq),
        .overrun(overrun), .dma_req(dma_req), .dma_addr_inc(dma_addr_inc)
    );

    // {data[20:9], slot[8:5], irq[4], channel before conversion[3:0]}; group of 5, mask 0xA014
    localparam logic [20:0] VEC [7] = '{
        {12'h101, 4'd0, 1'b0, 4'd2},
        {12'h202, 4'd1, 1'b0, 4'd4},
        {12'h303, 4'd2, 1'b0, 4'd13},
        {12'h404, 4'd3, 1'b0, 4'd15},
        {12'h505, 4'd4, 1'b1, 4'd2},
        {12'h606, 4'd0, 1'b1, 4'd2},
        {12'h707, 4'd1, 1'b1, 4'd4}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_conv(input logic [11:0] d);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        conv_done = 1'b1;
        conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int addr, input int exp);
        rd_addr = addr[3:0];
        rd_en = 1'b1;
        #1;
        chk(req, "rd_data", int'(rd_data), exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic bounce_enable();
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", "irq", int'(irq), 0);
        chk("R9", "done", int'(done), 0);
        chk("R9", "overrun", int'(overrun), 0);
        chk("R9", "dma_req", int'(dma_req), 0);
        chk("R9", "dma_addr_inc", int'(dma_addr_inc), 0);
        rd_chk("R9", 5, 0);

        // Table walk: sequential mode, group of 5, scan over channels 2,4,13,15
        cfg_group_m1 = 5'd4;
        cfg_scan_en = 1'b1;
        cfg_scan_mask = 16'hA014;
        enable = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            chk("R7", "cur_chan", int'(cur_chan), int'(VEC[i][3:0]));
            do_conv(VEC[i][20:9]);
            chk("R1", "irq", int'(irq), int'(VEC[i][4]));
            chk("R3", "dma_req seq mode", int'(dma_req), 0);
            rd_chk("R2", int'(VEC[i][8:5]), int'(VEC[i][20:9]));
        end
        rd_chk("R2", 2, 12'h303);
        chk("R7", "cur_chan after walk", int'(cur_chan), 13);
        pulse_irq_clr();
        chk("R1", "irq cleared", int'(irq), 0);

        // R6 DONE behaviour
        chk("R6", "done held", int'(done), 1);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        chk("R6", "done after start", int'(done), 0);
        conv_done = 1'b1;
        conv_data = 12'h808;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6", "done sticky", int'(done), 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R6", "done after clear", int'(done), 0);

        // Finish the group: conv 9 to slot 3, conv 10 ends group at slot 4
        do_conv(12'h909);
        chk("R1", "irq mid group", int'(irq), 0);
        do_conv(12'hA0A);
        chk("R1", "irq at group end", int'(irq), 1);
        rd_chk("R2", 4, 12'hA0A);

        // R8: events ignored while disabled
        enable = 1'b0;
        conv_done = 1'b1;
        conv_data = 12'hEEE;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R8", "irq disabled", int'(irq), 0);
        chk("R8", "done unchanged", int'(done), 1);
        rd_chk("R8", 0, 12'h606);
        enable = 1'b1;
        @(negedge clk);
        do_conv(12'h0A1);
        do_conv(12'h0B2);
        chk("R7", "cur_chan mid scan", int'(cur_chan), 13);
        bounce_enable();
        chk("R8", "scan index reset", int'(cur_chan), 2);
        do_conv(12'h0C3);
        rd_chk("R8", 0, 12'h0C3);
        rd_chk("R8", 1, 12'h0B2);

        // Group of 1, scan off
        enable = 1'b0;
        cfg_group_m1 = 5'd0;
        cfg_scan_en = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk("R7", "cur_chan scan off", int'(cur_chan), 0);
        do_conv(12'h111);
        chk("R1", "irq group of one", int'(irq), 1);
        rd_chk("R2", 0, 12'h111);
        pulse_irq_clr();
        do_conv(12'h222);
        chk("R1", "irq again", int'(irq), 1);
        rd_chk("R2", 0, 12'h222);
        rd_chk("R2", 1, 12'h0B2);

        // Group of 32: pointer wraps after 16 slots, no interrupt after 17
        enable = 1'b0;
        cfg_group_m1 = 5'd31;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 17; k++) do_conv(12'h100 + 12'(k));
        chk("R1", "irq before 32", int'(irq), 0);
        rd_chk("R2", 0, 12'h110);
        rd_chk("R2", 1, 12'h101);

        // DMA mode, group of 2
        enable = 1'b0;
        cfg_dma_en = 1'b1;
        cfg_group_m1 = 5'd1;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        do_conv(12'hA01);
        chk("R3", "dma_req pulse", int'(dma_req), 1);
        chk("R4", "dma_addr_inc mid group", int'(dma_addr_inc), 0);
        chk("R5", "overrun first", int'(overrun), 0);
        @(negedge clk);
        chk("R3", "dma_req one cycle", int'(dma_req), 0);
        do_conv(12'hA02);
        chk("R4", "dma_addr_inc at group end", int'(dma_addr_inc), 1);
        chk("R5", "overrun set", int'(overrun), 1);
        chk("R1", "irq dma group", int'(irq), 1);
        rd_chk("R3", 1, 12'h101);
        chk("R5", "overrun kept", int'(overrun), 1);
        rd_chk("R3", 0, 12'hA02);
        chk("R5", "overrun cleared by read", int'(overrun), 0);
        chk("R4", "dma_addr_inc one cycle", int'(dma_addr_inc), 0);
        do_conv(12'hA03);
        chk("R5", "no overrun after read", int'(overrun), 0);
        chk("R4", "dma_addr_inc new group", int'(dma_addr_inc), 0);

        summary();
        $finish;
    end
endmodule